// File: doc/BRIEF.md
# Timer-Based Baud Rate Generator

This block is a 16-bit up-counter with a 16-bit reload register that software presets. It makes the bit-rate ticks for a serial port. It has two run modes, and the control register picks between them. In plain timer mode the counter advances once every 12 clocks. When it rolls over it raises an overflow flag and wraps to zero. In baud-generator mode, which is active whenever either tick-select bit is set, the counter advances once every 2 clocks. Each rollover reloads the counter from the reload register. The rollover stream is then divided by 16 to give the serial tick, so the tick rate is fclk / (32 × (65536 − reload)).

The transmit tick and the receive tick each choose their source on their own. A side whose select bit is set takes the generator tick. A side whose select bit is clear passes through a tick that another timer supplies. This lets the two directions run at different rates. An external pin, gated by an enable bit, sets a flag on a falling edge. In baud-generator mode that edge only raises the flag and never reloads the counter, so the pin acts as a spare interrupt source. The interrupt output is the OR of the two flags.

Software reaches the control byte, the counter and the reload register through a byte-wide register port. A write lands at the clock edge that captures it. Read data is registered and appears one cycle after the address.

Top module: `baud_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0: control (address 0), counter bytes (addresses 1 and 2, low byte first) and reload bytes (addresses 3 and 4, low byte first). `tx_tick`, `rx_tick` and `irq` are low.
- R2: When control bit 1 (transmit select) or bit 2 (receive select) is set, the block is in baud-generator mode. In this mode each counter rollover loads the counter from the reload register. The generator tick is a single-cycle pulse that comes once every 16 rollovers, so it repeats every 32 × (65536 − reload) clocks.
- R3: In baud-generator mode a rollover never sets the overflow flag (control bit 6), and it never raises `irq`.
- R4: In timer mode (bits 1 and 2 both clear) with run set, the counter advances once every 12 clocks. A rollover wraps the counter to 0 and sets control bit 6, which drives `irq` high.
- R5: A falling edge on `ext_pin` sets the external flag (control bit 7) only while control bit 3 (edge enable) is set. With bit 3 clear, such an edge leaves the flag at 0.
- R6: In baud-generator mode, an `ext_pin` falling edge does not reload the counter, so the generator tick spacing stays the same.
- R7: `tx_tick` follows the generator when bit 1 is set, and otherwise follows `alt_tx_tick` delayed one clock. `rx_tick` does the same with bit 2 and `alt_rx_tick`. The two sides choose independently.
- R8: The counter holds its value while control bit 0 (run) is clear.
- R9: Writing 0 to control bits 6 and 7 clears the flags. A flag set by hardware in the same cycle as the write wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1-2 counter, 3-4 reload) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| ext_pin | input | 1 | External event pin, falling edge active |
| alt_tx_tick | input | 1 | Transmit tick from another timer |
| alt_rx_tick | input | 1 | Receive tick from another timer |
| tx_tick | output | 1 | Transmit baud tick, registered |
| rx_tick | output | 1 | Receive baud tick, registered |
| irq | output | 1 | OR of the overflow and external flags |

## Verification
Register reads are sampled one clock after the address is set. A control write that sets run counts as edge 0, so in timer mode the first advance lands at edge 12 and a rollover from 0xFFFE lands at edge 24. The bench reads before and after those edges. The tick outputs sit one register behind the generator or the alternate input. For that reason the scoreboard compares the spacing between successive pulses, not absolute times, and skips the first pulse after each reconfiguration. An external edge can take up to one count interval plus two synchronizer stages to register, so flag checks wait well past that window.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
  // control byte field positions
  localparam int CB_RUN  = 0;
  localparam int CB_TXS  = 1;
  localparam int CB_RXS  = 2;
  localparam int CB_EXEN = 3;
  localparam int CB_OVF  = 6;
  localparam int CB_EXF  = 7;

  typedef struct packed {
    logic run;
    logic tx_sel;
    logic rx_sel;
    logic ext_en;
    logic ovf_flag;
    logic ext_flag;
  } bt_ctrl_t;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int TIMER_DIV = 12,
  parameter int BAUD_DIV  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic baud_mode,
  output logic ce
);
  localparam int PW = $clog2(TIMER_DIV);
  localparam logic [PW-1:0] LIM_T = PW'(TIMER_DIV - 1);
  localparam logic [PW-1:0] LIM_B = PW'(BAUD_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim = baud_mode ? LIM_B : LIM_T;
  assign ce  = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (ce)     pre_q <= '0;
    else             pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic                 baud_mode,
  input  logic [CNT_W/DATA_W-1:0] cnt_we,
  input  logic [CNT_W/DATA_W-1:0] rld_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     reload,
  output logic                 ovf
);
  localparam int NB = CNT_W / DATA_W;

  logic [CNT_W-1:0] cnt_q, cnt_n, rld_q, rld_n;

  assign ovf    = ce && (cnt_q == '1);
  assign cnt    = cnt_q;
  assign reload = rld_q;

  always_comb begin
    cnt_n = cnt_q;
    if (ce) cnt_n = ovf ? (baud_mode ? rld_q : '0) : cnt_q + CNT_W'(1);
    rld_n = rld_q;
    for (int i = 0; i < NB; i++) begin
      if (cnt_we[i]) cnt_n[i*DATA_W +: DATA_W] = wdata;
      if (rld_we[i]) rld_n[i*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      rld_q <= rld_n;
    end
  end
endmodule

// File: rtl/bt_edge.sv
module bt_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic pin,
  output logic fall
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  assign fall = sample_en && prev_q && !sync_q[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin};
      if (sample_en) prev_q <= sync_q[SYNC-1];
    end
  end
endmodule

// File: rtl/bt_baud_div.sv
module bt_baud_div #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic ovf,
  output logic tick
);
  logic [DIV_W-1:0] div_q;

  assign tick = enable && ovf && (div_q == '1);

  always_ff @(posedge clk) begin
    if (rst)                div_q <= '0;
    else if (enable && ovf) div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import baud_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int TIMER_DIV = 12,
  parameter int BAUD_DIV  = 2,
  parameter int DIV_W     = 4,
  parameter int SYNC      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_pin,
  input  logic              alt_tx_tick,
  input  logic              alt_rx_tick,
  output logic              tx_tick,
  output logic              rx_tick,
  output logic              irq
);
  localparam int NB = CNT_W / DATA_W;

  bt_ctrl_t          ctl_q;
  logic              baud_mode, ce, ovf, fall, gen_tick;
  logic              ctrl_wr, ovf_set, ext_set;
  logic [NB-1:0]     cnt_we, rld_we;
  logic [CNT_W-1:0]  cnt, reload;
  logic [DATA_W-1:0] ctrl_byte, rd_next, rd_q;
  logic              tx_q, rx_q;

  assign baud_mode = ctl_q.tx_sel || ctl_q.rx_sel;
  assign ctrl_wr   = reg_wr && (reg_addr == '0);
  assign ovf_set   = ovf && !baud_mode;
  assign ext_set   = fall && ctl_q.ext_en;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      cnt_we[i] = reg_wr && (reg_addr == ADDR_W'(1 + i));
      rld_we[i] = reg_wr && (reg_addr == ADDR_W'(1 + NB + i));
    end
  end

  bt_prescaler #(.TIMER_DIV(TIMER_DIV), .BAUD_DIV(BAUD_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_q.run), .baud_mode(baud_mode), .ce(ce)
  );

  bt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .ce(ce), .baud_mode(baud_mode),
    .cnt_we(cnt_we), .rld_we(rld_we), .wdata(reg_wdata),
    .cnt(cnt), .reload(reload), .ovf(ovf)
  );

  bt_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst(rst), .sample_en(ce), .pin(ext_pin), .fall(fall)
  );

  bt_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .enable(baud_mode), .ovf(ovf), .tick(gen_tick)
  );

  // control register: hardware set wins over software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctl_q.run    <= reg_wdata[CB_RUN];
        ctl_q.tx_sel <= reg_wdata[CB_TXS];
        ctl_q.rx_sel <= reg_wdata[CB_RXS];
        ctl_q.ext_en <= reg_wdata[CB_EXEN];
      end
      ctl_q.ovf_flag <= (ctrl_wr ? reg_wdata[CB_OVF] : ctl_q.ovf_flag) | ovf_set;
      ctl_q.ext_flag <= (ctrl_wr ? reg_wdata[CB_EXF] : ctl_q.ext_flag) | ext_set;
    end
  end

  always_comb begin
    ctrl_byte          = '0;
    ctrl_byte[CB_RUN]  = ctl_q.run;
    ctrl_byte[CB_TXS]  = ctl_q.tx_sel;
    ctrl_byte[CB_RXS]  = ctl_q.rx_sel;
    ctrl_byte[CB_EXEN] = ctl_q.ext_en;
    ctrl_byte[CB_OVF]  = ctl_q.ovf_flag;
    ctrl_byte[CB_EXF]  = ctl_q.ext_flag;
    rd_next = '0;
    if (reg_addr == '0) rd_next = ctrl_byte;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(1 + i))      rd_next = cnt[i*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(1 + NB + i)) rd_next = reload[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      rd_q <= rd_next;
      tx_q <= ctl_q.tx_sel ? gen_tick : alt_tx_tick;
      rx_q <= ctl_q.rx_sel ? gen_tick : alt_rx_tick;
    end
  end

  assign reg_rdata = rd_q;
  assign tx_tick   = tx_q;
  assign rx_tick   = rx_q;
  assign irq       = ctl_q.ovf_flag | ctl_q.ext_flag;
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ce,
  input logic              baud_mode,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic              ext_en,
  input logic              gen_tick
);
  logic ctrl_wr, cnt_wr;
  assign ctrl_wr = reg_wr && (reg_addr == '0);
  assign cnt_wr  = reg_wr && (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2));

  assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && baud_mode && cnt == '1 && !cnt_wr) |=> cnt == $past(reload));

  assert_single_tick_R2: assert property (@(posedge clk) disable iff (rst)
    gen_tick |=> !gen_tick);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (baud_mode && !ovf_flag && !ctrl_wr) |=> !ovf_flag);

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && !baud_mode && cnt == '1) |=> ovf_flag);

  assert_ext_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!ext_en && !ext_flag && !ctrl_wr) |=> !ext_flag);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));
endmodule

bind baud_timer bt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .ce(ce), .baud_mode(baud_mode), .run(ctl_q.run), .cnt(cnt),
  .reload(reload), .ovf_flag(ctl_q.ovf_flag), .ext_flag(ctl_q.ext_flag),
  .ext_en(ctl_q.ext_en), .gen_tick(gen_tick)
);

// File: tb/baud_timer_test.sv
module baud_timer_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1;
  logic       alt_tx_tick = 0, alt_rx_tick = 0;
  logic       tx_tick, rx_tick, irq;

  int checks = 0, errors = 0;
  int cyc = 0;
  int txq[$], rxq[$];
  int tx_last = 0, rx_last = 0;
  int exp_iv;
  bit done = 0;
  logic [7:0] rv, rv2;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_timer uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .alt_tx_tick(alt_tx_tick), .alt_rx_tick(alt_rx_tick),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while ((txq.size() > 0 || rxq.size() > 0) && n < limit) begin
      @(negedge clk); n++;
    end
    check("scoreboard drain", txq.size() + rxq.size(), 0);
    txq.delete(); rxq.delete();
  endtask

  // monitor: compares tick spacing against queued expectations (0 = skip)
  always @(negedge clk) begin
    if (tx_tick) begin
      if (txq.size() > 0) begin
        exp_iv = txq.pop_front();
        if (exp_iv != 0) check("R2/R7 tx interval", cyc - tx_last, exp_iv);
      end
      tx_last = cyc;
    end
    if (rx_tick) begin
      if (rxq.size() > 0) begin
        exp_iv = rxq.pop_front();
        if (exp_iv != 0) check("R2/R7 rx interval", cyc - rx_last, exp_iv);
      end
      rx_last = cyc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 tx_tick in reset", tx_tick, 0);
    check("R1 irq in reset", irq, 0);
    rst = 0;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], rv);
      check("R1 register reset", rv, 0);
    end

    // R4: timer mode, rollover from 0xFFFE after two 12-clock steps
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    wr(3'd0, 8'h01);
    repeat (14) @(negedge clk);
    rd(3'd1, rv); check("R4 count after one step lo", rv, 8'hFF);
    rd(3'd0, rv); check("R4 flag not yet set", rv[6], 0);
    repeat (10) @(negedge clk);
    rd(3'd0, rv); check("R4 overflow flag", rv[6], 1);
    check("R4 irq", irq, 1);
    rd(3'd2, rv); check("R4 wrap to zero hi", rv, 8'h00);

    // R9 clear, R8 hold
    wr(3'd0, 8'h00);
    rd(3'd0, rv); check("R9 flags cleared", rv, 0);
    check("R9 irq cleared", irq, 0);
    rd(3'd1, rv);
    repeat (40) @(negedge clk);
    rd(3'd1, rv2); check("R8 counter holds", rv2, rv);

    // R2/R3: baud mode, reload 0xFFFC -> period 128; R5 gated edge
    wr(3'd3, 8'hFC); wr(3'd4, 8'hFF);
    wr(3'd1, 8'hFC); wr(3'd2, 8'hFF);
    txq = '{0, 128, 128, 128};
    rxq = '{0, 128, 128, 128};
    wr(3'd0, 8'h07);
    repeat (60) @(negedge clk);
    ext_pin = 0;
    rd(3'd2, rv); check("R2 counter stays in reload range hi", rv, 8'hFF);
    drain(2000);
    rd(3'd0, rv);
    check("R3 no overflow flag in baud mode", rv[6], 0);
    check("R5 edge ignored when disabled", rv[7], 0);
    check("R3 irq low", irq, 0);
    ext_pin = 1;
    repeat (20) @(negedge clk);

    // R5/R6: enabled edge sets flag, no reload
    txq = '{0, 128, 128, 128, 128};
    wr(3'd0, 8'h0F);
    repeat (190) @(negedge clk);
    ext_pin = 0;
    drain(2000);
    rd(3'd0, rv);
    check("R5 external flag set", rv[7], 1);
    check("R5 irq from external flag", irq, 1);
    check("R3 overflow flag still clear", rv[6], 0);
    ext_pin = 1;

    // R7: tx from generator, rx from alternate source
    wr(3'd0, 8'h03);
    txq = '{0, 128, 128};
    rxq = '{0, 50, 50, 50};
    for (int k = 0; k < 5; k++) begin
      repeat (49) @(negedge clk);
      alt_rx_tick = 1;
      @(negedge clk);
      alt_rx_tick = 0;
    end
    drain(2000);
    rd(3'd0, rv); check("R7 rx select clear", rv[2], 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule